// File: doc/BRIEF.md
# Dual-Group Programmable Tone Divider

This block produces two square-wave tones, a high group and a low group, from one fixed crystal clock of about 3.58 MHz. Software loads an 8-bit divisor into each group through a single write port. A shared prescaler divides the clock by 23. Each group then divides that tick by its divisor plus two. The resulting tone frequency is fclk / (23 × (N + 2)). A larger divisor gives a lower note. The divisors from 0x3D to 0xF8 cover two octaves in semitone steps, for example 0xF8 ≈ 622.5 Hz, 0x93 ≈ 1044.5 Hz and 0x40 ≈ 2358.1 Hz.

A divisor of zero switches its group off and holds that output low. Loading a note into the high group and zero into the low group therefore plays a single musical tone. A new divisor is not applied at once. It is taken up at the group's next period boundary, so no shortened pulse ever appears on the output. The two tones are also provided as a 2-bit combined level for a simple summing stage downstream.

Top module: `tone_pair_div`

## Requirements
- R1: While reset is held, and on the first cycle after it, tone_hi, tone_lo and tone_sum are 0. Both divisor registers reset to 0.
- R2: With a nonzero high-group divisor N, consecutive rising edges of tone_hi are exactly 23 × (N + 2) clock cycles apart.
- R3: Each high phase of an enabled tone lasts 23 × floor((N + 2) / 2) clocks. The low phase takes the rest of the period.
- R4: A group whose active divisor is 0 holds its output low. This is also the state straight after reset.
- R5: The low group obeys the same period and high-phase rule as the high group, using its own divisor and independently of it.
- R6: A written divisor takes effect only at the group's next period boundary. A write that lands in the very cycle of a boundary is applied at the following boundary. Outputs change only on prescaler ticks.
- R7: tone_sum carries the number of tone outputs currently high (0, 1 or 2).
- R8: A write with wr_sel = 1 loads the high-group divisor, and a write with wr_sel = 0 loads the low-group divisor. A write to one group leaves the other group's waveform unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal clock (nominally 3.579545 MHz) |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Divisor write strobe, one cycle |
| wr_sel | input | 1 | Target group: 1 = high group, 0 = low group |
| wr_data | input | 8 | Divisor value; 0 disables the group |
| tone_hi | output | 1 | High-group square wave |
| tone_lo | output | 1 | Low-group square wave |
| tone_sum | output | 2 | Count of tone outputs currently high |

## Verification
The delicate case is a divisor write that arrives in the same clock edge at which the group reloads its period counter. The bench locks onto a rising edge of tone_hi and counts exactly one period of clocks. It then asserts the write strobe so that the strobe is sampled on the reload edge itself. The scoreboard expects two more periods at the old length and only then the new length. A design that forwards the fresh value into the reload, or that applies it at once, shows a wrong period and is reported.

// File: rtl/tone_pkg.sv
// Package: shared constants and group indices for the tone divider.
// Assumes a single clock domain; all values are compile-time constants.
package tone_pkg;
    localparam int unsigned TONE_PRE_DIV = 23;
    localparam int unsigned TONE_DIV_W   = 8;
    localparam int unsigned TONE_GROUPS  = 2;

    typedef enum logic {
        GRP_LO = 1'b0,
        GRP_HI = 1'b1
    } tone_grp_e;
endpackage

// File: rtl/tone_prescaler.sv
// Module: tone_prescaler
// Divides the crystal clock by PRE_DIV and emits a one-cycle tick on the
// last count. Assumes PRE_DIV >= 2 so that ticks never occur back to back.
module tone_prescaler #(
    parameter int unsigned PRE_DIV = 23
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

    logic [PW-1:0] cnt_q;

    // Free-running modulo-PRE_DIV counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/tone_channel.sv
// Module: tone_channel
// One tone group. It holds a software divisor register and an active copy
// of it that is reloaded only at period boundaries. It also holds a period
// counter clocked by the prescaler tick and a registered square-wave output.
// Period = cur+2 ticks; the output is high for the first (cur+2)/2 ticks.
// An active divisor of zero keeps the output low, while the counter keeps
// cycling every 2 ticks so that a new value is picked up quickly.
module tone_channel #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wr_data,
    output logic [DIV_W-1:0] div_q,
    output logic [DIV_W-1:0] cur_q,
    output logic             tone
);
    localparam int unsigned CW = DIV_W + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;
    logic [CW-1:0] last_cnt;
    logic [CW-1:0] hi_len;
    logic          enabled;

    // Software-visible divisor register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (wr_en) begin
            div_q <= wr_data;
        end
    end

    // Derived period limits for the active divisor.
    always_comb begin
        cnt_nxt  = cnt_q + 1'b1;
        last_cnt = {1'b0, cur_q} + CW'(1);
        hi_len   = ({1'b0, cur_q} + CW'(2)) >> 1;
        enabled  = |cur_q;
    end

    // Period counter, boundary reload of the active divisor, output shaping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cur_q <= '0;
            tone  <= 1'b0;
        end else if (tick) begin
            if (cnt_q == last_cnt) begin
                cnt_q <= '0;
                cur_q <= div_q;
                tone  <= |div_q;
            end else begin
                cnt_q <= cnt_nxt;
                tone  <= enabled && (cnt_nxt < hi_len);
            end
        end
    end
endmodule

// File: rtl/tone_pair_div.sv
// Module: tone_pair_div (top)
// Two tone groups share one prescaler and one write port. wr_sel picks the
// target group. The combined output counts how many tones are high.
// Assumes a single crystal clock and synchronous active-low reset.
module tone_pair_div #(
    parameter int unsigned PRE_DIV = tone_pkg::TONE_PRE_DIV,
    parameter int unsigned DIV_W   = tone_pkg::TONE_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [DIV_W-1:0] wr_data,
    output logic             tone_hi,
    output logic             tone_lo,
    output logic [1:0]       tone_sum
);
    localparam int unsigned NG = tone_pkg::TONE_GROUPS;

    logic             tick;
    logic [NG-1:0]    tone_v;
    logic [DIV_W-1:0] div_v [NG];
    logic [DIV_W-1:0] cur_v [NG];
    logic [DIV_W-1:0] hi_div_w;
    logic [DIV_W-1:0] hi_cur_w;

    tone_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    for (genvar g = 0; g < NG; g++) begin : g_grp
        tone_channel #(.DIV_W(DIV_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .wr_en   (wr_en && (wr_sel == 1'(g))),
            .wr_data (wr_data),
            .div_q   (div_v[g]),
            .cur_q   (cur_v[g]),
            .tone    (tone_v[g])
        );
    end

    // Route group outputs to named ports and form the combined level.
    always_comb begin
        tone_hi  = tone_v[tone_pkg::GRP_HI];
        tone_lo  = tone_v[tone_pkg::GRP_LO];
        tone_sum = {1'b0, tone_v[1]} + {1'b0, tone_v[0]};
        hi_div_w = div_v[tone_pkg::GRP_HI];
        hi_cur_w = cur_v[tone_pkg::GRP_HI];
    end
endmodule

// File: rtl/tone_pair_div_chk.sv
// Module: tone_pair_div_chk
// Assertion checker bound into tone_pair_div. It watches the ports, the
// shared tick and the high group's divisor registers.
module tone_pair_div_chk #(
    parameter int unsigned DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_sel,
    input logic [DIV_W-1:0] wr_data,
    input logic             tone_hi,
    input logic             tone_lo,
    input logic [1:0]       tone_sum,
    input logic             tick,
    input logic [DIV_W-1:0] hi_div,
    input logic [DIV_W-1:0] hi_cur
);
    p_reset_low_r1: assert property (@(posedge clk)
        !rst_n |=> (!tone_hi && !tone_lo && tone_sum == 2'd0));

    p_off_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cur == '0) |-> !tone_hi);

    p_tone_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(tone_hi) && $stable(tone_lo)));

    p_active_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(hi_cur));

    p_sum_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({tone_hi, tone_lo}) == 32'(tone_sum));

    p_write_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (hi_div == $past(wr_data)));

    p_write_lo_keeps_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> $stable(hi_div));
endmodule

bind tone_pair_div tone_pair_div_chk #(.DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .tone_hi  (tone_hi),
    .tone_lo  (tone_lo),
    .tone_sum (tone_sum),
    .tick     (tick),
    .hi_div   (hi_div_w),
    .hi_cur   (hi_cur_w)
);

// File: tb/tone_pair_div_bench.sv
// Bench: a driver loads divisors and pushes the expected high-group periods
// into a queue. A negedge monitor measures tone_hi and compares the result
// against each expected item as it pops it.
module tone_pair_div_bench;
    localparam time CLK_PERIOD = 10ns;
    localparam int  PRE        = 23;

    typedef struct {
        int    period;
        int    high;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tone_hi, tone_lo;
    logic [1:0] tone_sum;

    int   n_chk = 0;
    int   n_fail = 0;
    exp_t q[$];

    tone_pair_div u_tone_pair_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .tone_hi  (tone_hi),
        .tone_lo  (tone_lo),
        .tone_sum (tone_sum)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int per_of(int n);
        return PRE * (n + 2);
    endfunction

    function automatic int high_of(int n);
        return PRE * ((n + 2) / 2);
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic wr(bit sel, int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = 8'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Monitor: measures rise-to-rise period and high time of tone_hi.
    int  cyc = 0;
    int  last_rise = 0;
    int  hi_meas = 0;
    bit  have_rise = 0;
    bit  hi_prev = 0;
    always @(negedge clk) begin
        cyc++;
        if (tone_hi && !hi_prev) begin
            if (have_rise && q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check({e.tag, " period"}, cyc - last_rise, e.period);
                check({e.tag, " high"}, hi_meas, e.high);
            end
            last_rise = cyc;
            have_rise = 1;
        end
        if (!tone_hi && hi_prev) hi_meas = cyc - last_rise;
        hi_prev = tone_hi;
    end

    // Driver: load N into the high group, skip the transition, expect periods.
    task automatic run_hi(int n, int count, string tag);
        wr(1'b1, n);
        @(posedge tone_hi);
        @(posedge tone_hi);
        for (int i = 0; i < count; i++) q.push_back('{per_of(n), high_of(n), tag});
        wait (q.size() == 0);
    endtask

    // Direct measurement of the low group over one full period.
    task automatic measure_lo(int n, string tag);
        int t0, t1, tf;
        bit p;
        p = tone_lo;
        while (!(tone_lo && !p)) begin p = tone_lo; @(negedge clk); end
        t0 = cyc; tf = 0;
        p = 1;
        @(negedge clk);
        while (!(tone_lo && !p)) begin
            if (!tone_lo && p) tf = cyc;
            p = tone_lo;
            @(negedge clk);
        end
        t1 = cyc;
        check({tag, " lo period"}, t1 - t0, per_of(n));
        check({tag, " lo high"}, tf - t0, high_of(n));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        int highs, bad, both;
        // R1: reset state
        repeat (4) @(negedge clk);
        check("R1 tone_hi in reset", int'(tone_hi), 0);
        check("R1 tone_lo in reset", int'(tone_lo), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 tone_sum after reset", int'(tone_sum), 0);
        // R4: both groups idle after reset
        highs = 0;
        for (int i = 0; i < 300; i++) begin @(negedge clk); highs += int'(tone_hi) + int'(tone_lo); end
        check("R4 idle after reset", highs, 0);

        // R8/R5: low group alone, then high group
        wr(1'b0, 8'h10);
        repeat (1000) @(negedge clk);
        check("R8 high untouched by low write", int'(tone_hi), 0);
        measure_lo(8'h10, "R5");
        run_hi(8'hF8, 2, "R2 R3 F8");
        measure_lo(8'h10, "R8 lo with hi running");
        run_hi(8'h93, 2, "R2 R3 93");
        run_hi(8'h3D, 2, "R2 R3 3D");
        run_hi(8'h40, 2, "R2 R3 40");

        // R6: write sampled on the reload edge itself
        @(posedge tone_hi);
        q.push_back('{per_of(8'h40), high_of(8'h40), "R6 before"});
        q.push_back('{per_of(8'h40), high_of(8'h40), "R6 current"});
        q.push_back('{per_of(8'h40), high_of(8'h40), "R6 boundary write"});
        q.push_back('{per_of(8'h93), high_of(8'h93), "R6 new value"});
        @(negedge clk);
        repeat (per_of(8'h40) - 1) @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'h93;
        @(negedge clk);
        wr_en = 1'b0;
        wait (q.size() == 0);

        // R7: combined level
        bad = 0; both = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (int'(tone_sum) != int'(tone_hi) + int'(tone_lo)) bad++;
            if (tone_sum == 2'd2) both++;
        end
        check("R7 sum mismatches", bad, 0);
        check("R7 both high seen", int'(both > 0), 1);

        // R4: zero divisor stops the high group, low keeps running (R8)
        wr(1'b1, 8'h00);
        repeat (6000) @(negedge clk);
        highs = 0;
        for (int i = 0; i < 6000; i++) begin @(negedge clk); highs += int'(tone_hi); end
        check("R4 hi held low", highs, 0);
        measure_lo(8'h10, "R8 lo after hi off");
        wr(1'b0, 8'h00);
        repeat (1000) @(negedge clk);
        check("R4 both off sum", int'(tone_sum), 0);
        finish_up();
    end
endmodule